// File: doc/BRIEF.md
# Restartable Reload Baud Generator

This block sets the bit timing of a serial port. Two down-counters share one 15-bit reload value. One counter paces the transmitter and the other paces the receiver. Each counter issues a single-cycle bit-clock enable when it passes through zero. The counters advance either on every system clock or on each rising edge of an external clock pin, which is first resynchronised. A configuration input selects the source. The present value of each counter is driven onto a status port, so software or a debug path can read the live count.

The receive counter has a restart input. The start-bit detector pulses this input on the falling edge of an incoming start bit. The pulse reloads the receive counter at once with half the reload value, so the receive timebase lines up with the new frame and later samples fall near mid-bit. The transmit counter does not see the restart and runs freely. The block has no data path, so every pin is a plain control or status signal. No valid/ready handshake applies.

Top module: `baud_reload_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, both counts read 0 and both tick outputs are low.
- R2: With `use_ext_clk` = 0 and a non-zero reload value R, each counter decrements by one on every clock until it reaches 0. The next clock then reloads it to R. Each counter therefore repeats the sequence R, R-1, …, 0 with a period of R+1 clocks.
- R3: A tick output goes high for exactly one clock. It rises in the cycle after the clock edge at which an enabled step found its counter at 0 and reloaded it. With R = 1 the ticks come on every second clock.
- R4: While the reload value is 0, both counters are forced to 0 and no tick is produced.
- R5: A high `rx_restart` with a non-zero reload value loads the receive counter with floor(R/2) on that clock. It suppresses any receive tick from that step and leaves the transmit counter untouched. Restart takes priority over a step.
- R6: With `use_ext_clk` = 1, `ext_clk_in` passes through two synchronising flip-flops and then an edge detector. A counter step happens on the clock after the second stage first shows 1 following a 0. Without a rising edge the counters hold.
- R7: A change of the reload value does not disturb a running count. The new value is used at the next reload from zero, or at the next restart.
- R8: Apart from the restart, the receive counter follows the same rules as the transmit counter. After a restart it keeps counting from floor(R/2) under those rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_ext_clk | input | 1 | 0: step on every clock; 1: step on resynchronised rising edges of `ext_clk_in` |
| ext_clk_in | input | 1 | External count clock, asynchronous |
| reload_val | input | 15 | Reload value R; 0 stops both counters |
| rx_restart | input | 1 | Start-bit restart request for the receive counter |
| tx_tick | output | 1 | Transmit bit-clock enable, one cycle wide |
| rx_tick | output | 1 | Receive bit-clock enable, one cycle wide |
| tx_count | output | 15 | Live transmit counter value |
| rx_count | output | 15 | Live receive counter value |

## Verification
The assertions take for granted that `reload_val`, `use_ext_clk` and `rx_restart` are synchronous to `clk`. The decrement property also relies on the internal source being selected and the reload value being non-zero, and it is stated only under that condition. The bench changes every input half a clock away from the active edge. It holds `ext_clk_in` level for at least one full clock, even in its fastest toggling phase, so the resynchroniser never has to resolve a mid-cycle change. Restart pulses are single clocks placed at arbitrary points in a count, including the cycle in which a tick would otherwise fire.

// File: rtl/brg_pkg.sv
package brg_pkg;
  parameter int unsigned BRG_CNT_W = 15;
  parameter int unsigned BRG_SYNC_STAGES = 2;

  typedef enum logic {
    SRC_SYSCLK = 1'b0,
    SRC_PIN    = 1'b1
  } brg_src_e;
endpackage

// File: rtl/brg_step_source.sv
module brg_step_source
  import brg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = BRG_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_ext_clk,
  input  logic ext_clk_in,
  output logic step_en
);
  localparam int unsigned CHAIN_LEN = SYNC_STAGES + 1;

  logic [CHAIN_LEN-1:0] chain_q;
  logic                 pin_rise;
  brg_src_e             src;

  // resynchroniser plus one history stage for edge detection
  genvar gi;
  generate
    for (gi = 0; gi < CHAIN_LEN; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= ext_clk_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign pin_rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign src      = brg_src_e'(use_ext_clk);

  always_comb begin
    unique case (src)
      SRC_PIN:    step_en = pin_rise;
      default:    step_en = 1'b1;
    endcase
  end
endmodule

// File: rtl/brg_reload_counter.sv
module brg_reload_counter
  import brg_pkg::*;
#(
  parameter int unsigned W = BRG_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic [W-1:0] reload_val,
  input  logic         restart,
  output logic         tick,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q;
  logic         tick_q;
  logic [W-1:0] half_val;
  logic         stopped;
  logic         at_zero;

  assign half_val = reload_val >> 1;
  assign stopped  = (reload_val == ZERO);
  assign at_zero  = (cnt_q == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= ZERO;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (stopped) begin
        cnt_q <= ZERO;
      end else if (restart) begin
        cnt_q <= half_val;
      end else if (step_en) begin
        if (at_zero) begin
          cnt_q  <= reload_val;
          tick_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign tick  = tick_q;
  assign count = cnt_q;
endmodule

// File: rtl/baud_reload_gen.sv
module baud_reload_gen
  import brg_pkg::*;
#(
  parameter int unsigned W           = BRG_CNT_W,
  parameter int unsigned SYNC_STAGES = BRG_SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         use_ext_clk,
  input  logic         ext_clk_in,
  input  logic [W-1:0] reload_val,
  input  logic         rx_restart,
  output logic         tx_tick,
  output logic         rx_tick,
  output logic [W-1:0] tx_count,
  output logic [W-1:0] rx_count
);
  logic step_en;

  brg_step_source #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk         (clk),
    .rst_n       (rst_n),
    .use_ext_clk (use_ext_clk),
    .ext_clk_in  (ext_clk_in),
    .step_en     (step_en)
  );

  // transmit timebase never restarts
  brg_reload_counter #(.W(W)) u_tx_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .reload_val (reload_val),
    .restart    (1'b0),
    .tick       (tx_tick),
    .count      (tx_count)
  );

  brg_reload_counter #(.W(W)) u_rx_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .reload_val (reload_val),
    .restart    (rx_restart),
    .tick       (rx_tick),
    .count      (rx_count)
  );
endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
  parameter int unsigned W = 15
) (
  input logic         clk,
  input logic         rst_n,
  input logic         use_ext_clk,
  input logic [W-1:0] reload_val,
  input logic         rx_restart,
  input logic         tx_tick,
  input logic         rx_tick,
  input logic [W-1:0] tx_count,
  input logic [W-1:0] rx_count
);
  assert_tx_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_ext_clk && reload_val != '0 && tx_count != '0) |=> (tx_count == $past(tx_count) - W'(1)));

  assert_tx_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |=> !tx_tick);

  assert_rx_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick |=> !rx_tick);

  assert_tick_after_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0 && reload_val != '0 && !use_ext_clk) |=> (tx_tick && tx_count == $past(reload_val)));

  assert_zero_reload_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_val == '0) |=> (tx_count == '0 && rx_count == '0 && !tx_tick && !rx_tick));

  assert_restart_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_restart && reload_val != '0) |=> (rx_count == ($past(reload_val) >> 1) && !rx_tick));
endmodule

bind baud_reload_gen brg_checker #(.W(W)) u_brg_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .use_ext_clk (use_ext_clk),
  .reload_val  (reload_val),
  .rx_restart  (rx_restart),
  .tx_tick     (tx_tick),
  .rx_tick     (rx_tick),
  .tx_count    (tx_count),
  .rx_count    (rx_count)
);

// File: tb/tb_baud_reload_gen.sv
`timescale 1ns/1ps
module tb_baud_reload_gen;
  localparam int W = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         use_ext_clk = 1'b0;
  logic         ext_clk_in = 1'b0;
  logic [W-1:0] reload_val = '0;
  logic         rx_restart = 1'b0;
  logic         tx_tick, rx_tick;
  logic [W-1:0] tx_count, rx_count;

  int    vectors = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string req = "R1";

  // reference state
  int m_tx = 0, m_rx = 0;
  bit m_ttk = 0, m_rtk = 0;
  bit m_s1 = 0, m_s2 = 0, m_s3 = 0;

  always #10 clk = ~clk;

  baud_reload_gen dut (
    .clk(clk), .rst_n(rst_n), .use_ext_clk(use_ext_clk), .ext_clk_in(ext_clk_in),
    .reload_val(reload_val), .rx_restart(rx_restart),
    .tx_tick(tx_tick), .rx_tick(rx_tick), .tx_count(tx_count), .rx_count(rx_count)
  );

  // behavioural reference, advanced once per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_ttk = 0; m_rtk = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit en;
      int r;
      r  = int'(reload_val);
      en = use_ext_clk ? (m_s2 && !m_s3) : 1'b1;
      m_ttk = 0; m_rtk = 0;
      if (r == 0) begin
        m_tx = 0; m_rx = 0;
      end else begin
        if (en) begin
          if (m_tx == 0) begin m_tx = r; m_ttk = 1; end
          else m_tx = m_tx - 1;
        end
        if (rx_restart) m_rx = r / 2;
        else if (en) begin
          if (m_rx == 0) begin m_rx = r; m_rtk = 1; end
          else m_rx = m_rx - 1;
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk_in;
    end
  end

  // compare away from the edge
  always @(posedge clk) begin
    #5;
    if (!done) begin
      vectors++;
      if (tx_count !== W'(m_tx) || rx_count !== W'(m_rx) ||
          tx_tick !== m_ttk || rx_tick !== m_rtk) begin
        fails++;
        $display("FAIL %s t=%0t: tx_count=%0d rx_count=%0d tx_tick=%0b rx_tick=%0b expected %0d %0d %0b %0b",
                 req, $time, tx_count, rx_count, tx_tick, rx_tick, m_tx, m_rx, m_ttk, m_rtk);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    req = "R1";
    cycles(3);
    rst_n = 1'b1;
    cycles(2);

    // R2: internal source, R=3 then R=6
    req = "R2";
    reload_val = 15'd3;
    cycles(20);
    reload_val = 15'd6;
    cycles(30);

    // R3: fastest ticks with R=1
    req = "R3";
    reload_val = 15'd1;
    cycles(12);

    // R4: zero reload stops everything
    req = "R4";
    reload_val = 15'd0;
    rx_restart = 1'b1;
    cycles(2);
    rx_restart = 1'b0;
    cycles(10);

    // R5: restarts at assorted points, odd and large values
    req = "R5";
    reload_val = 15'd9;
    cycles(7);
    for (int i = 0; i < 8; i++) begin
      rx_restart = 1'b1;
      cycles(1);
      rx_restart = 1'b0;
      cycles(3 + i);
    end
    reload_val = 15'h7FFF;
    cycles(5);
    rx_restart = 1'b1;
    cycles(1);
    rx_restart = 1'b0;
    cycles(5);

    // R6: external clock, slow then fastest toggling
    req = "R6";
    reload_val = 15'd2;
    use_ext_clk = 1'b1;
    for (int i = 0; i < 60; i++) begin
      ext_clk_in = ((i / 3) % 2) == 1;
      cycles(1);
    end
    for (int i = 0; i < 30; i++) begin
      ext_clk_in = ~ext_clk_in;
      cycles(1);
    end
    cycles(8);
    use_ext_clk = 1'b0;
    ext_clk_in = 1'b0;

    // R7: reload change during a running count
    req = "R7";
    reload_val = 15'd10;
    cycles(14);
    reload_val = 15'd4;
    cycles(20);
    reload_val = 15'd12;
    cycles(3);
    rx_restart = 1'b1;
    cycles(1);
    rx_restart = 1'b0;
    cycles(20);

    // R8: receive counter after restart runs under the normal rules
    req = "R8";
    reload_val = 15'd7;
    cycles(5);
    rx_restart = 1'b1;
    cycles(1);
    rx_restart = 1'b0;
    cycles(40);

    // R1 again: mid-run reset
    req = "R1";
    rst_n = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(5);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule